// File: doc/BRIEF.md
# Serial Bus Master Write Sequencer

This block is the master side of a two-wire serial bus (SMBus/I2C style) for a write transfer. Software runs it through a few strobes and status bits. It loads a byte into the data holding register, asks for a START, and then answers one interrupt per byte. On a START request from idle, the block puts a START condition on the bus. It then shifts out the held byte, which carries the 7-bit target address and the direction bit (0 for a write), most significant bit first.

After every byte the block gives a ninth clock for the acknowledge. It raises its interrupt flag only once that ninth clock has finished, and it keeps SCL low until software clears the flag. What happens when the flag is cleared depends on what software did in the meantime:
- If software requested a STOP, the block sends the STOP condition.
- Otherwise, if software wrote a new byte, the block transmits that byte.
- Otherwise, the block switches to receiving and clocks a byte in from the slave.

Both bus lines are open-drain. The block either pulls a line low or releases it, and it reads SDA back for sampling. The SCL low and high phases each last a fixed number of system clocks, set by parameters.

Top module: `smb_master_wr`

## Requirements
- R1: After reset both lines are released, and `irq`, `ack_rx`, `tx_mode` and `dat_out` are all 0.
- R2: A `sta_req` pulse while idle produces a START: SDA falls while SCL is high. The block then sends the held byte on 8 SCL pulses, most significant bit first.
- R3: Within a byte, every SCL high phase lasts exactly `HI_CYC` clocks. Every SCL low phase between two bits of the same byte lasts exactly `LO_CYC` clocks.
- R4: When transmitting, the block releases SDA during the ninth clock and samples it at the end of that clock's high phase. `ack_rx` becomes 1 if SDA was low (acknowledged) and 0 if SDA was high.
- R5: `irq` is set only after the ninth clock of a byte has completed, never after the eighth bit. While `irq` is set, SCL is held low and no further SCL edge occurs.
- R6: If `irq` is cleared with no STOP pending, and a byte was written after the last load, that byte is transmitted and `tx_mode` reads 1. Any number of bytes can follow in one transfer.
- R7: If `irq` is cleared with no STOP pending and no byte written, the block enters receive mode and `tx_mode` reads 0. It releases SDA for 8 clocks, shifts the bits in most significant first, and drives SDA low on the ninth clock. `dat_out` holds the byte when `irq` next rises.
- R8: If a STOP is already pending when the eighth bit of a received byte completes, the block leaves SDA released on the ninth clock (not acknowledged).
- R9: Clearing `irq` with a STOP pending produces a STOP, and this takes priority over a written byte. SDA is pulled low while SCL is low, then SCL is released, then SDA rises while SCL is high. The block then returns to idle with both lines released.
- R10: `sta_req` has no effect during a transfer, so no repeated START and no second transfer follow. `sto_req` has no effect while idle, so the next transfer is not ended early.
- R11: Apart from START and STOP, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_in | input | DW | Byte written into the holding register |
| dat_wr | input | 1 | Write strobe for `dat_in` |
| sta_req | input | 1 | Request a START (honoured when idle) |
| sto_req | input | 1 | Request a STOP at the next byte boundary |
| irq_clr | input | 1 | Clear the byte interrupt flag |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Byte-done interrupt flag |
| ack_rx | output | 1 | Last sampled acknowledge, 1 means acknowledged |
| tx_mode | output | 1 | 1 if the current or last byte was transmitted |
| dat_out | output | DW | Last byte received |

## Verification
The hardest case to reach is the fall into receive mode followed by a not-acknowledged ninth clock. It needs software to clear the interrupt without writing data. It then needs a STOP request that arrives after the receive byte has started but before its eighth bit ends. The bench gets there with a bus-level slave model whose transmit byte and acknowledge choice are reprogrammed while SCL is held low. It pulses `sto_req` a few cycles after `irq_clr`. A scoreboard of expected START, byte-with-acknowledge and STOP items is compared against what a line monitor decodes from SCL and SDA. The monitor also times each SCL phase.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STA_A,
    ST_STA_B,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_WAIT,
    ST_STO_A,
    ST_STO_B,
    ST_STO_C
  } smb_state_e;

endpackage

// File: rtl/smb_phase_timer.sv
module smb_phase_timer #(
  parameter int LO_CYC = 5,
  parameter int HI_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_hi,
  output logic expire
);

  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] LO_M1 = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] HI_M1 = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] TOP   = CW'(MAXC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = sel_hi ? HI_M1 : LO_M1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/smb_shifter.sv
module smb_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          shift_in,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[DW-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dat_in,
  input  logic          dat_wr,
  input  logic          sta_req,
  input  logic          sto_req,
  input  logic          irq_clr,
  input  logic          sda_in,
  input  logic          expire,
  input  logic [DW-1:0] sh_q,
  output logic          tmr_restart,
  output logic          tmr_sel_hi,
  output logic          sh_load,
  output logic          sh_shift,
  output logic [DW-1:0] sh_load_val,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq,
  output logic          ack_rx,
  output logic          tx_mode,
  output logic [DW-1:0] dat_out
);

  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] ACK_IDX  = BCW'(DW);
  localparam logic [BCW-1:0] LAST_IDX = BCW'(DW - 1);

  smb_state_e     state_q, state_d;
  logic [BCW-1:0] bitcnt_q, bitcnt_d;
  logic           tx_q, tx_d;
  logic           irq_q, irq_d;
  logic           ack_q, ack_d;
  logic           sta_pend_q, sta_pend_d;
  logic           sto_pend_q, sto_pend_d;
  logic           full_q, full_d;
  logic [DW-1:0]  hold_q, hold_d;
  logic [DW-1:0]  dout_q, dout_d;
  logic           nack_q, nack_d;
  logic           scl_q, scl_d;
  logic           sda_q, sda_d;
  logic           busy, ack_end, last_end;

  assign busy     = (state_q == ST_STA_A) || (state_q == ST_STA_B) ||
                    (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI) ||
                    (state_q == ST_WAIT);
  assign ack_end  = (state_q == ST_BIT_HI) && expire && (bitcnt_q == ACK_IDX);
  assign last_end = (state_q == ST_BIT_HI) && expire && (bitcnt_q == LAST_IDX);

  // sequencing
  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    tx_d     = tx_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (sta_pend_q) state_d = ST_STA_A;
      ST_STA_A: if (expire) state_d = ST_STA_B;
      ST_STA_B: if (expire) begin
        state_d  = ST_BIT_LO;
        bitcnt_d = '0;
        sh_load  = 1'b1;
        tx_d     = 1'b1;
      end
      ST_BIT_LO: if (expire) state_d = ST_BIT_HI;
      ST_BIT_HI: if (expire) begin
        if (bitcnt_q == ACK_IDX) begin
          state_d = ST_WAIT;
        end else begin
          state_d  = ST_BIT_LO;
          sh_shift = 1'b1;
          bitcnt_d = bitcnt_q + 1'b1;
        end
      end
      ST_WAIT: if (!irq_q) begin
        if (sto_pend_q) begin
          state_d = ST_STO_A;
        end else begin
          state_d  = ST_BIT_LO;
          bitcnt_d = '0;
          tx_d     = full_q;
          sh_load  = full_q;
        end
      end
      ST_STO_A: if (expire) state_d = ST_STO_B;
      ST_STO_B: if (expire) state_d = ST_STO_C;
      ST_STO_C: if (expire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tmr_restart = (state_d != state_q);
  assign tmr_sel_hi  = (state_d == ST_STA_A) || (state_d == ST_STA_B) ||
                       (state_d == ST_BIT_HI) || (state_d == ST_STO_B) ||
                       (state_d == ST_STO_C);
  assign sh_load_val = hold_q;

  // software-facing flags and holding registers
  always_comb begin
    sta_pend_d = (state_q == ST_IDLE) && (sta_req || sta_pend_q) && (state_d == ST_IDLE);
    sto_pend_d = busy && (sto_req || sto_pend_q) && (state_d != ST_STO_A);
    full_d     = dat_wr || (full_q && !sh_load);
    hold_d     = dat_wr ? dat_in : hold_q;
    irq_d      = ack_end ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
    ack_d      = (ack_end && tx_q) ? !sda_in : ack_q;
    dout_d     = (ack_end && !tx_q) ? sh_q : dout_q;
    nack_d     = last_end ? sto_pend_q : nack_q;
  end

  // line drivers: SCL follows the next state, SDA lags one clock behind
  always_comb begin
    scl_d = (state_d == ST_BIT_LO) || (state_d == ST_WAIT) || (state_d == ST_STO_A);
    unique case (state_q)
      ST_STA_B, ST_STO_A, ST_STO_B: sda_d = 1'b1;
      ST_BIT_LO, ST_BIT_HI: begin
        if (bitcnt_q != ACK_IDX) sda_d = tx_q && !sh_q[DW-1];
        else                     sda_d = !tx_q && !nack_q;
      end
      default: sda_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      tx_q       <= 1'b0;
      irq_q      <= 1'b0;
      ack_q      <= 1'b0;
      sta_pend_q <= 1'b0;
      sto_pend_q <= 1'b0;
      full_q     <= 1'b0;
      hold_q     <= '0;
      dout_q     <= '0;
      nack_q     <= 1'b0;
      scl_q      <= 1'b0;
      sda_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      bitcnt_q   <= bitcnt_d;
      tx_q       <= tx_d;
      irq_q      <= irq_d;
      ack_q      <= ack_d;
      sta_pend_q <= sta_pend_d;
      sto_pend_q <= sto_pend_d;
      full_q     <= full_d;
      hold_q     <= hold_d;
      dout_q     <= dout_d;
      nack_q     <= nack_d;
      scl_q      <= scl_d;
      sda_q      <= sda_d;
    end
  end

  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  assign irq     = irq_q;
  assign ack_rx  = ack_q;
  assign tx_mode = tx_q;
  assign dat_out = dout_q;

  assert_irq_holds_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> scl_q);

  assert_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (state_q == ST_WAIT));

  assert_sda_only_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && $past(!scl_q) && !$stable(sda_q)) |->
      ((state_q == ST_STA_B) || (state_q == ST_STO_C)));

  assert_ack_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_q) |-> $past(state_q == ST_BIT_HI && bitcnt_q == ACK_IDX && tx_q));

  assert_load_starts_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> (state_q == ST_BIT_LO && tx_q));

  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= ACK_IDX);

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!scl_q && !sda_q));

endmodule

// File: rtl/smb_master_wr.sv
module smb_master_wr #(
  parameter int DW          = 8,
  parameter int LO_CYC      = 5,
  parameter int HI_CYC      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dat_in,
  input  logic          dat_wr,
  input  logic          sta_req,
  input  logic          sto_req,
  input  logic          irq_clr,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq,
  output logic          ack_rx,
  output logic          tx_mode,
  output logic [DW-1:0] dat_out
);

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_pipe_q[SYNC_STAGES-1];

  logic          expire, tmr_restart, tmr_sel_hi;
  logic          sh_load, sh_shift;
  logic [DW-1:0] sh_q, sh_load_val;

  smb_phase_timer #(
    .LO_CYC (LO_CYC),
    .HI_CYC (HI_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_i),
    .restart (tmr_restart),
    .sel_hi  (tmr_sel_hi),
    .expire  (expire)
  );

  smb_shifter #(
    .DW (DW)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (sh_load),
    .load_val (sh_load_val),
    .shift    (sh_shift),
    .shift_in (sda_in),
    .q        (sh_q)
  );

  smb_ctrl #(
    .DW (DW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_i),
    .dat_in      (dat_in),
    .dat_wr      (dat_wr),
    .sta_req     (sta_req),
    .sto_req     (sto_req),
    .irq_clr     (irq_clr),
    .sda_in      (sda_in),
    .expire      (expire),
    .sh_q        (sh_q),
    .tmr_restart (tmr_restart),
    .tmr_sel_hi  (tmr_sel_hi),
    .sh_load     (sh_load),
    .sh_shift    (sh_shift),
    .sh_load_val (sh_load_val),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .irq         (irq),
    .ack_rx      (ack_rx),
    .tx_mode     (tx_mode),
    .dat_out     (dat_out)
  );

endmodule

// File: tb/smb_master_wr_tb.sv
module smb_master_wr_tb;

  localparam int LO = 5;
  localparam int HI = 4;
  localparam logic [1:0] K_START = 2'd1, K_BYTE = 2'd2, K_STOP = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] dat_in = '0;
  logic dat_wr = 0, sta_req = 0, sto_req = 0, irq_clr = 0;
  logic scl_oe, sda_oe, irq, ack_rx, tx_mode;
  logic [7:0] dat_out;

  // bus-level slave model
  logic       slv_tx = 0, slv_ack = 1, slv_low;
  logic [7:0] slv_byte = '0;
  int         bitpos = 9;
  logic       scl_line, sda_line;

  always_comb begin
    if (bitpos < 8)       slv_low = slv_tx && !slv_byte[3'(7 - bitpos)];
    else if (bitpos == 8) slv_low = !slv_tx && slv_ack;
    else                  slv_low = 1'b0;
  end
  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !slv_low;

  smb_master_wr #(.DW(8), .LO_CYC(LO), .HI_CYC(HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .dat_in(dat_in), .dat_wr(dat_wr),
    .sta_req(sta_req), .sto_req(sto_req), .irq_clr(irq_clr),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .ack_rx(ack_rx), .tx_mode(tx_mode), .dat_out(dat_out)
  );

  int total = 0, bad = 0;
  logic [10:0] exp_q[$];
  int nbytes = 0, nrises = 0, nobs = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic observe(input logic [10:0] item);
    nobs++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R11 unexpected bus item", int'(item), 0);
    end else begin
      logic [10:0] e;
      e = exp_q.pop_front();
      chk(item == e, "R2/R4/R7/R8/R9 scoreboard item", int'(item), int'(e));
    end
  endtask

  // line monitor
  initial begin
    logic ps, pd, first_fall;
    int rcnt, hilen, lolen;
    logic [7:0] sh;
    ps = 1; pd = 1; first_fall = 1; rcnt = 0; hilen = 0; lolen = 0; sh = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (scl_line && ps && pd && !sda_line) begin
        observe({K_START, 9'd0});
        rcnt = 0; bitpos = 9; first_fall = 1;
      end else if (scl_line && ps && !pd && sda_line) begin
        observe({K_STOP, 9'd0});
        bitpos = 9;
      end
      if (scl_line && !ps) begin
        nrises++;
        if (rcnt != 0) chk(lolen == LO, "R3 SCL low phase", lolen, LO);
        if (rcnt < 8) begin
          sh = {sh[6:0], sda_line};
        end else begin
          nbytes++;
          observe({K_BYTE, !sda_line, sh});
        end
        rcnt = (rcnt == 8) ? 0 : rcnt + 1;
        hilen = 1;
      end else if (!scl_line && ps) begin
        if (!first_fall) chk(hilen == HI, "R3 SCL high phase", hilen, HI);
        first_fall = 0;
        bitpos = rcnt;
        lolen = 1;
      end else if (scl_line) begin
        hilen++;
      end else begin
        lolen++;
      end
      ps = scl_line; pd = sda_line;
    end
  end

  task automatic wr_data(input logic [7:0] b);
    @(negedge clk); dat_in = b; dat_wr = 1;
    @(negedge clk); dat_wr = 0;
  endtask
  task automatic pulse_sta(); @(negedge clk); sta_req = 1; @(negedge clk); sta_req = 0; endtask
  task automatic pulse_sto(); @(negedge clk); sto_req = 1; @(negedge clk); sto_req = 0; endtask
  task automatic pulse_clr(); @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; endtask
  task automatic wait_irq(); while (!irq) @(negedge clk); endtask
  task automatic wait_idle();
    int st;
    st = 0;
    while (st < 20) begin
      @(negedge clk);
      st = (scl_line && sda_line) ? st + 1 : 0;
    end
  endtask

  logic done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nb, nr, no;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(scl_line == 1, "R1 SCL released", scl_line, 1);
    chk(sda_line == 1, "R1 SDA released", sda_line, 1);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(ack_rx == 0, "R1 ack_rx", ack_rx, 0);
    chk(tx_mode == 0 && dat_out == 0, "R1 tx_mode/dat_out", {tx_mode, dat_out}, 0);

    // R10: stop request while idle does nothing
    pulse_sto();
    repeat (40) @(negedge clk);
    chk(nobs == 0 && scl_line && sda_line, "R10 stop ignored when idle", nobs, 0);

    // transfer 1: address + data bytes, slave acknowledges
    slv_tx = 0; slv_ack = 1;
    wr_data(8'hA4);
    exp_q.push_back({K_START, 9'd0});
    exp_q.push_back({K_BYTE, 1'b1, 8'hA4});
    pulse_sta();
    repeat (30) @(negedge clk);
    pulse_sta();                      // R10: ignored while busy
    wait_irq();
    chk(nbytes == 1, "R5 irq after ninth clock", nbytes, 1);
    chk(ack_rx == 1, "R4 ack sampled", ack_rx, 1);
    chk(tx_mode == 1, "R2 address sent in tx mode", tx_mode, 1);
    nr = nrises;
    repeat (40) @(negedge clk);
    chk(scl_line == 0 && nrises == nr && irq, "R5 SCL held while irq", nrises - nr, 0);

    wr_data(8'h3C);
    exp_q.push_back({K_BYTE, 1'b1, 8'h3C});
    pulse_clr();
    wait_irq();
    chk(nbytes == 2 && tx_mode == 1, "R6 second byte sent", nbytes, 2);
    chk(ack_rx == 1, "R4 ack on data", ack_rx, 1);

    slv_ack = 0;                      // slave refuses next byte
    wr_data(8'hC3);
    exp_q.push_back({K_BYTE, 1'b0, 8'hC3});
    pulse_clr();
    wait_irq();
    chk(ack_rx == 0, "R4 nack sampled", ack_rx, 0);
    chk(nbytes == 3, "R6 third byte sent", nbytes, 3);

    // R9: stop wins over a freshly written byte
    wr_data(8'h11);
    exp_q.push_back({K_STOP, 9'd0});
    pulse_sto();
    pulse_clr();
    wait_idle();
    chk(exp_q.size() == 0, "R9 stop completed", exp_q.size(), 0);
    no = nobs;
    repeat (100) @(negedge clk);
    chk(nobs == no && scl_line && sda_line, "R10 start while busy ignored", nobs - no, 0);

    // transfer 2: address, then fall back to receive
    slv_ack = 1;
    wr_data(8'hA4);
    exp_q.push_back({K_START, 9'd0});
    exp_q.push_back({K_BYTE, 1'b1, 8'hA4});
    pulse_sta();
    wait_irq();
    chk(tx_mode == 1 && ack_rx == 1, "R10 stop from idle did not end transfer", {tx_mode, ack_rx}, 3);

    slv_tx = 1; slv_byte = 8'h5A;
    exp_q.push_back({K_BYTE, 1'b1, 8'h5A});
    nb = nbytes;
    pulse_clr();
    wait_irq();
    chk(tx_mode == 0, "R7 receive mode entered", tx_mode, 0);
    chk(dat_out == 8'h5A, "R7 received byte", dat_out, 8'h5A);
    chk(nbytes == nb + 1, "R7 one byte clocked", nbytes - nb, 1);

    slv_byte = 8'h96;
    exp_q.push_back({K_BYTE, 1'b0, 8'h96});   // R8: master leaves ninth bit released
    pulse_clr();
    repeat (5) @(negedge clk);
    pulse_sto();
    wait_irq();
    chk(dat_out == 8'h96, "R7 second received byte", dat_out, 8'h96);
    slv_tx = 0;
    exp_q.push_back({K_STOP, 9'd0});
    pulse_clr();
    wait_idle();
    chk(exp_q.size() == 0, "R8/R9 receive then stop", exp_q.size(), 0);
    chk(irq == 0 && scl_line && sda_line, "R9 idle after stop", irq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule